// File: doc/BRIEF.md
# Serial EEPROM Transaction Sequencer

This block turns one high-level request for a two-wire serial memory into an ordered series of commands for a separate bit-level bus engine. A request is a probe, a read or a write. It carries a 7-bit device address, a register address of 0 to `ALEN_MAX` bytes, and a byte count. Write payload is pulled from a valid/ready byte stream. Read payload is pushed out on a second valid/ready byte stream. When the transaction ends, the block reports an error flag and a count of data bytes that the device did not acknowledge.

The block issues one engine command at a time and waits for the engine's response before it issues the next. Each response carries the acknowledge bit and, for reads, the received byte.

Small memories that keep their upper address bits in the device-address field are handled by folding those bits into the device address. The fold uses a mask parameter. A second parameter selects what separates the address phase from the read phase. Bus waveform timing and bus recovery belong to the engine.

Top module: `eeseq_top`

## Requirements
- R1: After reset, and between transactions, `req_ready_o` is 1 and the block asserts no engine command, no write-stream ready, no read-stream valid and no `done_o`. `done_o` is a one-cycle pulse, and the block is idle in the cycle after it.
- R2: When a request is accepted, the device address sent on the bus is `req_chip_i | ((req_addr_i >> (8*req_alen_i)) & OVF_MASK)`. This folded address is used in every phase of the transaction.
- R3: Engine op codes are START=0, STOP=1, WRITE=2 and READ=3. A device-address byte is sent as WRITE with `{chip, rw}`, where rw is bit 0. For a probe, for a write, and for a read with a nonzero address length, the transaction begins with START and then WRITE `{chip,0}`. If that byte is NACKed, the next command is STOP, and the transaction ends with `err_o`=1.
- R4: The register address bytes follow, most significant byte first, one WRITE each. If any of them is NACKed, the next command is STOP, and the transaction ends with `err_o`=1.
- R5: A read with address length 0 skips the address phase. Its first START is followed directly by WRITE `{chip,1}`.
- R6: On a read with a nonzero address length, a repeated START follows the last address byte when `RESTART_EN`=1. When `RESTART_EN`=0 (the default), STOP and then START follow it.
- R7: A read sends WRITE `{chip,1}`. If that byte is NACKed, STOP follows and `err_o`=1. Otherwise the block issues one READ per byte, with `eng_cmd_nack_o`=0 on every byte except the last, where it is 1. STOP follows. The received bytes leave on the read stream in order.
- R8: A write fetches each data byte from the write stream and sends it as a WRITE. A NACKed data byte does not stop the transfer. The NACKs are counted, and `nack_cnt_o` holds the count at `done_o`, with `err_o`=0.
- R9: Request op codes are 0 for probe, 1 for read and 2 for write; code 3 acts as a probe. A probe is START, WRITE `{chip,0}`, STOP. `err_o`=0 at `done_o` means the device acknowledged and is present.
- R10: A read or write with a byte count of 0 issues STOP right after its address phase and moves no data bytes.
- R11: An engine command that is not yet accepted is held stable. After it is accepted, no new command is offered until its response arrives.
- R12: A read byte that the consumer has not taken is held stable on `rd_data_o`, with `rd_valid_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request taken |
| req_op_i | input | 2 | Request kind: 0 probe, 1 read, 2 write |
| req_chip_i | input | 7 | Device address |
| req_addr_i | input | 8*ALEN_MAX | Register address |
| req_alen_i | input | clog2(ALEN_MAX+1) | Register address length in bytes |
| req_len_i | input | LEN_W | Data byte count |
| wr_valid_i | input | 1 | Write byte offered |
| wr_ready_o | output | 1 | Write byte taken |
| wr_data_i | input | 8 | Write byte |
| rd_valid_o | output | 1 | Read byte offered |
| rd_ready_i | input | 1 | Read byte taken |
| rd_data_o | output | 8 | Read byte |
| eng_cmd_valid_o | output | 1 | Engine command offered |
| eng_cmd_ready_i | input | 1 | Engine command accepted |
| eng_cmd_op_o | output | 2 | Engine op: START, STOP, WRITE, READ |
| eng_cmd_byte_o | output | 8 | Byte to send for WRITE |
| eng_cmd_nack_o | output | 1 | For READ: 1 sends NACK after the byte |
| eng_rsp_valid_i | input | 1 | Engine finished the command |
| eng_rsp_nack_i | input | 1 | For WRITE: the device did not acknowledge |
| eng_rsp_byte_i | input | 8 | For READ: received byte |
| done_o | output | 1 | Transaction complete (pulse) |
| err_o | output | 1 | Device or address NACK; valid at done_o |
| nack_cnt_o | output | LEN_W | NACKed write data bytes; valid at done_o |

## Verification
A wrong phase state, a wrong address index or a wrong remaining count appears on the engine command port as a wrong op code or byte. It shows up at the very next command the block offers, usually a few cycles after the faulty response. A wrong NACK count or error flag is only visible at the `done_o` pulse. A wrong last-byte flag shows up as the acknowledge bit on a READ command. The bench therefore compares the full command transcript of every transaction, together with the completion status and the delivered read bytes, against a model built from the requirements. It does this over every request kind, every address length, byte counts of 0 to 3, and several NACK placements.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;
  localparam logic [1:0] ENG_START = 2'd0;
  localparam logic [1:0] ENG_STOP  = 2'd1;
  localparam logic [1:0] ENG_WRITE = 2'd2;
  localparam logic [1:0] ENG_READ  = 2'd3;

  localparam logic [1:0] REQ_RD = 2'd1;
  localparam logic [1:0] REQ_WR = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_CHIPW, S_ADDR, S_MID_STOP, S_START2, S_CHIPR,
    S_WFETCH, S_WBYTE, S_RBYTE, S_RPUSH, S_STOP, S_DONE
  } seq_st_e;
endpackage

// File: rtl/eeseq_fold.sv
module eeseq_fold #(
  parameter int         ALEN_MAX = 4,
  parameter logic [6:0] OVF_MASK = 7'h03,
  localparam int        AW       = 8 * ALEN_MAX,
  localparam int        ALW      = $clog2(ALEN_MAX + 1)
) (
  input  logic [6:0]     chip_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [ALW-1:0] alen_i,
  output logic [6:0]     chip_o
);
  logic [6:0] spill;
  // bits above the sent address bytes spill into the device address
  assign spill  = 7'(addr_i >> {alen_i, 3'b000});
  assign chip_o = chip_i | (spill & OVF_MASK);
endmodule

// File: rtl/eeseq_cmd.sv
module eeseq_cmd
  import eeseq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int ALW = 3
) (
  input  seq_st_e        st_i,
  input  logic [6:0]     chip_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [ALW-1:0] idx_i,
  input  logic [7:0]     wbyte_i,
  input  logic           last_i,
  output logic [1:0]     op_o,
  output logic [7:0]     byte_o,
  output logic           nack_o
);
  logic [AW-1:0] addr_sh;
  assign addr_sh = addr_i >> {idx_i, 3'b000};

  always_comb begin
    op_o   = ENG_START;
    byte_o = 8'h00;
    nack_o = 1'b0;
    unique case (st_i)
      S_START, S_START2:  op_o = ENG_START;
      S_STOP, S_MID_STOP: op_o = ENG_STOP;
      S_CHIPW: begin op_o = ENG_WRITE; byte_o = {chip_i, 1'b0}; end
      S_CHIPR: begin op_o = ENG_WRITE; byte_o = {chip_i, 1'b1}; end
      S_ADDR:  begin op_o = ENG_WRITE; byte_o = addr_sh[7:0]; end
      S_WBYTE: begin op_o = ENG_WRITE; byte_o = wbyte_i; end
      S_RBYTE: begin op_o = ENG_READ;  nack_o = last_i; end
      default: ;
    endcase
  end
endmodule

// File: rtl/eeseq_fsm.sv
module eeseq_fsm
  import eeseq_pkg::*;
#(
  parameter int ALEN_MAX   = 4,
  parameter int LEN_W      = 8,
  parameter bit RESTART_EN = 1'b0,
  localparam int AW        = 8 * ALEN_MAX,
  localparam int ALW       = $clog2(ALEN_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_op_i,
  input  logic [6:0]       req_chip_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [ALW-1:0]   req_alen_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic             req_ready_o,
  input  logic             wr_valid_i,
  input  logic [7:0]       wr_data_i,
  output logic             wr_ready_o,
  input  logic             rd_ready_i,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o,
  input  logic             cmd_ready_i,
  output logic             cmd_valid_o,
  input  logic             rsp_valid_i,
  input  logic             rsp_nack_i,
  input  logic [7:0]       rsp_byte_i,
  output logic             done_o,
  output logic             err_o,
  output logic [LEN_W-1:0] nack_cnt_o,
  output seq_st_e          st_o,
  output logic [6:0]       chip_o,
  output logic [AW-1:0]    addr_o,
  output logic [ALW-1:0]   idx_o,
  output logic [7:0]       wbyte_o,
  output logic             last_o
);
  seq_st_e          st_q;
  logic             busy_q, err_q;
  logic [1:0]       op_q;
  logic [6:0]       chip_q;
  logic [AW-1:0]    addr_q;
  logic [ALW-1:0]   alen_q, idx_q;
  logic [LEN_W-1:0] len_q, ncnt_q;
  logic [7:0]       wbyte_q, rbyte_q;

  logic is_rd, is_wr, is_cmd_st;
  assign is_rd = (op_q == REQ_RD);
  assign is_wr = (op_q == REQ_WR);
  assign is_cmd_st = !(st_q inside {S_IDLE, S_WFETCH, S_RPUSH, S_DONE});

  function automatic seq_st_e data_entry(logic wr, logic [LEN_W-1:0] n);
    if (n == '0) return S_STOP;
    return wr ? S_WFETCH : S_RBYTE;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      op_q    <= '0;
      chip_q  <= '0;
      addr_q  <= '0;
      alen_q  <= '0;
      idx_q   <= '0;
      len_q   <= '0;
      ncnt_q  <= '0;
      wbyte_q <= '0;
      rbyte_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          op_q   <= req_op_i;
          chip_q <= req_chip_i;
          addr_q <= req_addr_i;
          alen_q <= req_alen_i;
          len_q  <= req_len_i;
          err_q  <= 1'b0;
          ncnt_q <= '0;
          st_q   <= S_START;
        end
        S_WFETCH: if (wr_valid_i) begin
          wbyte_q <= wr_data_i;
          st_q    <= S_WBYTE;
        end
        S_RPUSH: if (rd_ready_i) begin
          len_q <= len_q - 1'b1;
          st_q  <= (len_q == LEN_W'(1)) ? S_STOP : S_RBYTE;
        end
        S_DONE: st_q <= S_IDLE;
        default: begin
          if (!busy_q) begin
            if (cmd_ready_i) busy_q <= 1'b1;
          end else if (rsp_valid_i) begin
            busy_q <= 1'b0;
            case (st_q)
              S_START: st_q <= (is_rd && alen_q == '0) ? S_CHIPR : S_CHIPW;
              S_CHIPW: begin
                if (rsp_nack_i) begin
                  err_q <= 1'b1;
                  st_q  <= S_STOP;
                end else if (!is_rd && !is_wr) begin
                  st_q <= S_STOP;
                end else if (alen_q != '0) begin
                  idx_q <= alen_q - 1'b1;
                  st_q  <= S_ADDR;
                end else begin
                  st_q <= data_entry(1'b1, len_q);
                end
              end
              S_ADDR: begin
                if (rsp_nack_i) begin
                  err_q <= 1'b1;
                  st_q  <= S_STOP;
                end else if (idx_q != '0) begin
                  idx_q <= idx_q - 1'b1;
                end else if (is_rd) begin
                  st_q <= RESTART_EN ? S_START2 : S_MID_STOP;
                end else begin
                  st_q <= data_entry(1'b1, len_q);
                end
              end
              S_MID_STOP: st_q <= S_START2;
              S_START2:   st_q <= S_CHIPR;
              S_CHIPR: begin
                if (rsp_nack_i) begin
                  err_q <= 1'b1;
                  st_q  <= S_STOP;
                end else begin
                  st_q <= data_entry(1'b0, len_q);
                end
              end
              S_WBYTE: begin
                if (rsp_nack_i) ncnt_q <= ncnt_q + 1'b1;
                len_q <= len_q - 1'b1;
                st_q  <= (len_q == LEN_W'(1)) ? S_STOP : S_WFETCH;
              end
              S_RBYTE: begin
                rbyte_q <= rsp_byte_i;
                st_q    <= S_RPUSH;
              end
              S_STOP: st_q <= S_DONE;
              default: st_q <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign req_ready_o = (st_q == S_IDLE);
  assign wr_ready_o  = (st_q == S_WFETCH);
  assign rd_valid_o  = (st_q == S_RPUSH);
  assign rd_data_o   = rbyte_q;
  assign done_o      = (st_q == S_DONE);
  assign cmd_valid_o = is_cmd_st && !busy_q;
  assign err_o       = err_q;
  assign nack_cnt_o  = ncnt_q;
  assign st_o        = st_q;
  assign chip_o      = chip_q;
  assign addr_o      = addr_q;
  assign idx_o       = idx_q;
  assign wbyte_o     = wbyte_q;
  assign last_o      = (len_q == LEN_W'(1));
endmodule

// File: rtl/eeseq_top.sv
module eeseq_top
  import eeseq_pkg::*;
#(
  parameter int         ALEN_MAX   = 4,
  parameter int         LEN_W      = 8,
  parameter logic [6:0] OVF_MASK   = 7'h03,
  parameter bit         RESTART_EN = 1'b0,
  localparam int        AW         = 8 * ALEN_MAX,
  localparam int        ALW        = $clog2(ALEN_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_op_i,
  input  logic [6:0]       req_chip_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [ALW-1:0]   req_alen_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  input  logic [7:0]       wr_data_i,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic [7:0]       rd_data_o,
  output logic             eng_cmd_valid_o,
  input  logic             eng_cmd_ready_i,
  output logic [1:0]       eng_cmd_op_o,
  output logic [7:0]       eng_cmd_byte_o,
  output logic             eng_cmd_nack_o,
  input  logic             eng_rsp_valid_i,
  input  logic             eng_rsp_nack_i,
  input  logic [7:0]       eng_rsp_byte_i,
  output logic             done_o,
  output logic             err_o,
  output logic [LEN_W-1:0] nack_cnt_o
);
  logic [6:0]     chip_fold, chip_q;
  logic [AW-1:0]  addr_q;
  logic [ALW-1:0] idx_q;
  logic [7:0]     wbyte_q;
  logic           last_q;
  seq_st_e        st;

  eeseq_fold #(.ALEN_MAX(ALEN_MAX), .OVF_MASK(OVF_MASK)) u_fold (
    .chip_i(req_chip_i), .addr_i(req_addr_i), .alen_i(req_alen_i), .chip_o(chip_fold)
  );

  eeseq_fsm #(.ALEN_MAX(ALEN_MAX), .LEN_W(LEN_W), .RESTART_EN(RESTART_EN)) u_fsm (
    .clk_i, .rst_ni,
    .req_valid_i, .req_op_i, .req_chip_i(chip_fold), .req_addr_i, .req_alen_i, .req_len_i,
    .req_ready_o,
    .wr_valid_i, .wr_data_i, .wr_ready_o,
    .rd_ready_i, .rd_valid_o, .rd_data_o,
    .cmd_ready_i(eng_cmd_ready_i), .cmd_valid_o(eng_cmd_valid_o),
    .rsp_valid_i(eng_rsp_valid_i), .rsp_nack_i(eng_rsp_nack_i), .rsp_byte_i(eng_rsp_byte_i),
    .done_o, .err_o, .nack_cnt_o,
    .st_o(st), .chip_o(chip_q), .addr_o(addr_q), .idx_o(idx_q), .wbyte_o(wbyte_q),
    .last_o(last_q)
  );

  eeseq_cmd #(.AW(AW), .ALW(ALW)) u_cmd (
    .st_i(st), .chip_i(chip_q), .addr_i(addr_q), .idx_i(idx_q), .wbyte_i(wbyte_q),
    .last_i(last_q), .op_o(eng_cmd_op_o), .byte_o(eng_cmd_byte_o), .nack_o(eng_cmd_nack_o)
  );
endmodule

// File: rtl/eeseq_chk.sv
module eeseq_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             wr_ready_o,
  input logic             rd_valid_o,
  input logic             rd_ready_i,
  input logic [7:0]       rd_data_o,
  input logic             eng_cmd_valid_o,
  input logic             eng_cmd_ready_i,
  input logic [1:0]       eng_cmd_op_o,
  input logic [7:0]       eng_cmd_byte_o,
  input logic             eng_cmd_nack_o,
  input logic             done_o,
  input logic             err_o,
  input logic [LEN_W-1:0] nack_cnt_o
);
  a_r11_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_cmd_valid_o && !eng_cmd_ready_i |=> eng_cmd_valid_o && $stable(eng_cmd_op_o)
      && $stable(eng_cmd_byte_o) && $stable(eng_cmd_nack_o));

  a_r11_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_cmd_valid_o && eng_cmd_ready_i |=> !eng_cmd_valid_o);

  a_r12_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o));

  a_r1_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);

  a_r1_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_ready_o, wr_ready_o, rd_valid_o, eng_cmd_valid_o, done_o}));

  a_r8_status_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> nack_cnt_o == '0 && !err_o);
endmodule

bind eeseq_top eeseq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .wr_ready_o(wr_ready_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
  .rd_data_o(rd_data_o), .eng_cmd_valid_o(eng_cmd_valid_o),
  .eng_cmd_ready_i(eng_cmd_ready_i), .eng_cmd_op_o(eng_cmd_op_o),
  .eng_cmd_byte_o(eng_cmd_byte_o), .eng_cmd_nack_o(eng_cmd_nack_o), .done_o(done_o),
  .err_o(err_o), .nack_cnt_o(nack_cnt_o)
);

// File: tb/sim_eeseq_top.sv
module sim_eeseq_top;
  localparam int         CLK_PERIOD = 10;
  localparam logic [6:0] MASK_TB    = 7'h03;
  localparam bit         RS_TB      = 1'b0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_op = '0;
  logic [6:0]  req_chip = '0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_alen = '0;
  logic [7:0]  req_len = '0;
  logic        wr_valid = 1'b1, wr_ready;
  logic [7:0]  wr_data;
  logic        rd_valid, rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_byte;
  logic        cmd_nack;
  logic        rsp_valid = 1'b0, rsp_nack = 1'b0;
  logic [7:0]  rsp_byte = '0;
  logic        done, err;
  logic [7:0]  ncnt;

  eeseq_top #(.ALEN_MAX(4), .LEN_W(8), .OVF_MASK(MASK_TB), .RESTART_EN(RS_TB)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_chip_i(req_chip), .req_addr_i(req_addr), .req_alen_i(req_alen), .req_len_i(req_len),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_data_i(wr_data),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_data_o(rd_data),
    .eng_cmd_valid_o(cmd_valid), .eng_cmd_ready_i(cmd_ready), .eng_cmd_op_o(cmd_op),
    .eng_cmd_byte_o(cmd_byte), .eng_cmd_nack_o(cmd_nack),
    .eng_rsp_valid_i(rsp_valid), .eng_rsp_nack_i(rsp_nack), .eng_rsp_byte_i(rsp_byte),
    .done_o(done), .err_o(err), .nack_cnt_o(ncnt)
  );

  int n_chk = 0, n_bad = 0;

  // observed transcript
  logic [1:0]  log_op [64];
  logic [7:0]  log_b  [64];
  int          log_n = 0;
  int          w_ord = 0, r_ord = 0;
  logic [31:0] nack_mask = '0;
  logic [7:0]  rd_got [16];
  int          rd_n = 0;
  int          wr_idx = 0;

  // expected transcript
  logic [1:0]  exp_op [64];
  logic [7:0]  exp_b  [64];
  int          exp_n;
  logic [7:0]  exp_rd [16];
  int          exp_rdn;
  logic        exp_err;
  logic [7:0]  exp_ncnt;

  function automatic logic [7:0] wdat(int k);
    return 8'(k) ^ 8'h5A;
  endfunction

  assign wr_data = wdat(wr_idx);

  // engine model
  initial begin
    logic       nk;
    logic [7:0] rb;
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid) begin
        if (log_n < 64) begin
          log_op[log_n] = cmd_op;
          log_b[log_n]  = (cmd_op == 2'd2) ? cmd_byte :
                          (cmd_op == 2'd3) ? {7'd0, cmd_nack} : 8'h00;
          log_n++;
        end
        nk = 1'b0;
        rb = 8'h00;
        if (cmd_op == 2'd2) begin nk = nack_mask[w_ord[4:0]]; w_ord++; end
        if (cmd_op == 2'd3) begin rb = 8'hC3 + 8'(r_ord); r_ord++; end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        repeat (log_n % 3) @(negedge clk);
        rsp_valid = 1'b1; rsp_nack = nk; rsp_byte = rb;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  // write stream source
  initial begin
    logic pend = 1'b0;
    forever begin
      @(negedge clk);
      if (pend) begin wr_idx++; pend = 1'b0; end
      if (wr_ready && wr_valid) pend = 1'b1;
    end
  end

  // read stream sink with alternating ready
  initial begin
    forever begin
      @(negedge clk);
      rd_ready = ~rd_ready;
      if (rd_valid && rd_ready && rd_n < 16) begin rd_got[rd_n] = rd_data; rd_n++; end
    end
  end

  task automatic push(logic [1:0] op, logic [7:0] b);
    exp_op[exp_n] = op; exp_b[exp_n] = b; exp_n++;
  endtask

  task automatic build_exp(logic [1:0] op, logic [6:0] chip, logic [31:0] addr,
                           int alen, int len, logic [31:0] mask, int wbase);
    logic [6:0] f;
    int wk = 0;
    f = chip | (7'(64'(addr) >> (8 * alen)) & MASK_TB);
    exp_n = 0; exp_rdn = 0; exp_err = 1'b0; exp_ncnt = 8'd0;
    push(2'd0, 8'h00);
    if (!(op == 2'd1 && alen == 0)) begin
      push(2'd2, {f, 1'b0});
      if (mask[wk]) begin exp_err = 1'b1; push(2'd1, 8'h00); return; end
      wk++;
      if (op != 2'd1 && op != 2'd2) begin push(2'd1, 8'h00); return; end
      for (int i = alen - 1; i >= 0; i--) begin
        push(2'd2, addr[8*i +: 8]);
        if (mask[wk]) begin exp_err = 1'b1; push(2'd1, 8'h00); return; end
        wk++;
      end
      if (op == 2'd2) begin
        for (int j = 0; j < len; j++) begin
          push(2'd2, wdat(wbase + j));
          if (mask[wk]) exp_ncnt++;
          wk++;
        end
        push(2'd1, 8'h00);
        return;
      end
      if (RS_TB) push(2'd0, 8'h00);
      else begin push(2'd1, 8'h00); push(2'd0, 8'h00); end
    end
    push(2'd2, {f, 1'b1});
    if (mask[wk]) begin exp_err = 1'b1; push(2'd1, 8'h00); return; end
    for (int j = 0; j < len; j++) begin
      push(2'd3, {7'd0, (j == len - 1)});
      exp_rd[j] = 8'hC3 + 8'(j);
      exp_rdn++;
    end
    push(2'd1, 8'h00);
  endtask

  task automatic check_txn(string tag);
    bit ok;
    int bad = -1;
    ok = (log_n == exp_n);
    if (ok) begin
      for (int i = 0; i < exp_n; i++) begin
        if (log_op[i] != exp_op[i] || log_b[i] != exp_b[i]) begin ok = 1'b0; bad = i; break; end
      end
    end
    n_chk++;
    if (!ok) begin
      n_bad++;
      if (bad < 0)
        $display("FAIL %s command count actual=%0d expected=%0d", tag, log_n, exp_n);
      else
        $display("FAIL %s command %0d actual=%0d/%02h expected=%0d/%02h", tag, bad,
                 log_op[bad], log_b[bad], exp_op[bad], exp_b[bad]);
    end
    n_chk++;
    if (err !== exp_err) begin
      n_bad++;
      $display("FAIL R3 R4 R7 R9 err_o actual=%0b expected=%0b", err, exp_err);
    end
    n_chk++;
    if (ncnt !== exp_ncnt) begin
      n_bad++;
      $display("FAIL R8 nack_cnt_o actual=%0d expected=%0d", ncnt, exp_ncnt);
    end
    ok = (rd_n == exp_rdn);
    bad = -1;
    if (ok) begin
      for (int i = 0; i < exp_rdn; i++) if (rd_got[i] != exp_rd[i]) begin ok = 1'b0; bad = i; break; end
    end
    n_chk++;
    if (!ok) begin
      n_bad++;
      if (bad < 0) $display("FAIL R7 R12 read count actual=%0d expected=%0d", rd_n, exp_rdn);
      else $display("FAIL R7 R12 read byte %0d actual=%02h expected=%02h", bad, rd_got[bad], exp_rd[bad]);
    end
  endtask

  task automatic run_txn(logic [1:0] op, logic [6:0] chip, logic [31:0] addr,
                         int alen, int len, logic [31:0] mask);
    string tag;
    build_exp(op, chip, addr, alen, len, mask, wr_idx);
    log_n = 0; w_ord = 0; r_ord = 0; rd_n = 0; nack_mask = mask;
    req_op = op; req_chip = chip; req_addr = addr;
    req_alen = 3'(alen); req_len = 8'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    if (op == 2'd1)      tag = "R2 R5 R6 R7 R10 R11 read";
    else if (op == 2'd2) tag = "R2 R3 R4 R8 R10 R11 write";
    else                 tag = "R2 R3 R9 R11 probe";
    check_txn(tag);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] masks [5];
    int t = 0;
    masks = '{32'h0, 32'h1, 32'h2, 32'h28, 32'hF0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (!(req_ready && !cmd_valid && !done && !wr_ready && !rd_valid)) begin
      n_bad++;
      $display("FAIL R1 idle after reset actual=%0b%0b%0b%0b%0b expected=10000",
               req_ready, cmd_valid, done, wr_ready, rd_valid);
    end
    for (int op = 0; op < 4; op++) begin
      for (int alen = 0; alen <= 4; alen++) begin
        for (int len = 0; len <= 3; len++) begin
          for (int m = 0; m < 5; m++) begin
            if (op == 3 && (len > 0 || m > 1)) continue;
            run_txn(2'(op), 7'((t * 13) & 7'h7F), 32'(t) * 32'h9E3779B1, alen, len, masks[m]);
            t++;
          end
        end
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule